// File: doc/BRIEF.md
# Bit-Swapped ROM Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and its program memories. It sorts every CPU address into one of four outcomes: the fixed ROM area, a banked ROM window, the non-volatile RAM, or an unused gap. It drives the matching chip select and, for ROM accesses, the 20-bit physical ROM address.

The bank is chosen by a byte that software writes to one I/O port. Before that byte is stored, every adjacent pair of data bits swaps places. The low six bits of the stored value give one of 64 banks of 8 KB each. The two top bits are an NMI enable and a memory-select flag, and both are brought out as outputs. Four consecutive 8 KB CPU windows all show the same selected bank.

Top module: `rom_bank_mapper`

## Requirements
- R1: A byte is stored in the bank register only on a clock edge where `ioWrEn` is 1 and `ioAddr` equals 0x90. A write to any other I/O address, or with `ioWrEn` at 0, leaves the register unchanged.
- R2: The stored value `s` is the written byte `d` with each adjacent bit pair swapped: s[7]=d[6], s[6]=d[7], s[5]=d[4], s[4]=d[5], s[3]=d[2], s[2]=d[3], s[1]=d[0], s[0]=d[1].
- R3: For CPU addresses 0x6000 to 0xDFFF, `romCs` is 1, `ramCs` is 0, and `romAddr` = 0x10000 + s[5:0] × 0x2000 + cpuAddr[12:0]. All four 8 KB windows in this range map to the same bank.
- R4: For CPU addresses 0x0000 to 0x57FF, `romCs` is 1, `ramCs` is 0, and `romAddr` equals `cpuAddr` zero-extended to 20 bits.
- R5: For CPU addresses 0xE000 to 0xFFFF, `ramCs` is 1, `romCs` is 0, and `romAddr` is 0.
- R6: For CPU addresses 0x5800 to 0x5FFF, both chip selects are 0 and `romAddr` is 0.
- R7: `nmiEnable` equals s[7] (written bit 6), and `memFlag` equals s[6] (written bit 7).
- R8: While `rstN` is low, the register clears to 0. This gives bank 0, NMI disabled and the memory flag at 0.
- R9: A new bank value takes effect at the clock edge that stores it. Address decode is combinational on `cpuAddr`, so no further clock is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU memory address |
| ioWrEn | input | 1 | I/O write strobe |
| ioAddr | input | 8 | I/O port address |
| ioData | input | 8 | I/O write data |
| romCs | output | 1 | ROM chip select (fixed area or banked window) |
| ramCs | output | 1 | Non-volatile RAM chip select |
| romAddr | output | 20 | Physical ROM address |
| nmiEnable | output | 1 | NMI enable flag from the bank register |
| memFlag | output | 1 | Memory-select flag from the bank register |

## Verification
The assertions check four things on every cycle:
- the two chip selects are never both active;
- the gap range and the RAM range drive the chip selects correctly;
- any banked access lands at or above the bank base;
- the register holds its value unless a write strobe decodes, and a decoded write moves written bit 6 into the NMI flag.

The exact pair-swap permutation, the arithmetic of the banked address across all four windows, and the boundary addresses at each range edge can only be shown by the bench. The bench also covers rejection of a write to a neighbouring port and the reset return to bank 0.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_FIXED  = 2'd1,
    RG_BANKED = 2'd2,
    RG_NVRAM  = 2'd3
  } region_e;

  typedef struct packed {
    logic    bankLoad;
    region_e region;
  } ctrl_strobe_t;

endpackage

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              IO_W      = 8,
  parameter logic [IO_W-1:0] IO_PORT   = 8'h90,
  parameter logic [ADDR_W-1:0] FIXED_TOP = 16'h57FF,
  parameter logic [ADDR_W-1:0] WIN_LO    = 16'h6000,
  parameter logic [ADDR_W-1:0] RAM_LO    = 16'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              ioWrEn,
  input  logic [IO_W-1:0]   ioAddr,
  output ctrl_strobe_t      strobes,
  output logic              romCs,
  output logic              ramCs
);

  region_e region;

  // Range decode; windows between WIN_LO and RAM_LO share one bank.
  always_comb begin
    if (cpuAddr <= FIXED_TOP)                         region = RG_FIXED;
    else if (cpuAddr >= WIN_LO && cpuAddr < RAM_LO)   region = RG_BANKED;
    else if (cpuAddr >= RAM_LO)                       region = RG_NVRAM;
    else                                              region = RG_NONE;
  end

  always_comb begin
    strobes.bankLoad = ioWrEn && (ioAddr == IO_PORT);
    strobes.region   = region;
  end

  assign romCs = (region == RG_FIXED) || (region == RG_BANKED);
  assign ramCs = (region == RG_NVRAM);

  // R5
  csExclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(romCs && ramCs));

  // R6
  gapNoSel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr > FIXED_TOP && cpuAddr < WIN_LO) |-> (!romCs && !ramCs));

  // R5
  ramRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramCs |-> (cpuAddr >= RAM_LO));

endmodule

// File: rtl/bankmap_dp.sv
module bankmap_dp
  import bankmap_pkg::*;
#(
  parameter int                  ADDR_W     = 16,
  parameter int                  DATA_W     = 8,
  parameter int                  BANK_W     = 6,
  parameter int                  WIN_LOG2   = 13,
  parameter int                  ROM_ADDR_W = 20,
  parameter logic [ROM_ADDR_W-1:0] BANK_BASE = 20'h10000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strobes,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  nmiEnable,
  output logic                  memFlag
);

  localparam int OFF_W = BANK_W + WIN_LOG2;
  localparam int PAIRS = DATA_W / 2;

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] bankReg;
  logic [BANK_W-1:0] bankNum;
  logic [OFF_W-1:0]  winOffset;

  // Each adjacent bit pair trades places.
  for (genvar p = 0; p < PAIRS; p++) begin : g_swap
    assign swapped[2*p]   = wrData[2*p+1];
    assign swapped[2*p+1] = wrData[2*p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bankReg <= '0;
    else if (strobes.bankLoad) bankReg <= swapped;
  end

  assign bankNum   = bankReg[BANK_W-1:0];
  assign winOffset = {bankNum, cpuAddr[WIN_LOG2-1:0]};
  assign nmiEnable = bankReg[DATA_W-1];
  assign memFlag   = bankReg[DATA_W-2];

  always_comb begin
    case (strobes.region)
      RG_FIXED:  romAddr = ROM_ADDR_W'(cpuAddr);
      RG_BANKED: romAddr = BANK_BASE + ROM_ADDR_W'(winOffset);
      default:   romAddr = '0;
    endcase
  end

  // R1
  holdBank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bankLoad |=> $stable(bankReg));

  // R7
  nmiLoad_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bankLoad |=> (nmiEnable == $past(wrData[DATA_W-2])));

  // R3
  bankedBase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.region == RG_BANKED) |-> (romAddr >= BANK_BASE));

endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import bankmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IO_W       = 8,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 6,
  parameter int WIN_LOG2   = 13,
  parameter int ROM_ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic                  ioWrEn,
  input  logic [IO_W-1:0]       ioAddr,
  input  logic [DATA_W-1:0]     ioData,
  output logic                  romCs,
  output logic                  ramCs,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  nmiEnable,
  output logic                  memFlag
);

  ctrl_strobe_t strobes;

  bankmap_ctrl #(
    .ADDR_W(ADDR_W), .IO_W(IO_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .ioWrEn(ioWrEn),
    .ioAddr(ioAddr), .strobes(strobes), .romCs(romCs), .ramCs(ramCs)
  );

  bankmap_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .WIN_LOG2(WIN_LOG2), .ROM_ADDR_W(ROM_ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .wrData(ioData), .romAddr(romAddr), .nmiEnable(nmiEnable),
    .memFlag(memFlag)
  );

endmodule

// File: tb/rom_bank_mapper_tb.sv
`timescale 1ns/1ps
module rom_bank_mapper_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic        romCs, ramCs, nmiEnable, memFlag;
  logic [19:0] romAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  rom_bank_mapper u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .ioWrEn(ioWrEn),
    .ioAddr(ioAddr), .ioData(ioData), .romCs(romCs), .ramCs(ramCs),
    .romAddr(romAddr), .nmiEnable(nmiEnable), .memFlag(memFlag)
  );

  // {data, cpuAddr, romCs, ramCs, romAddr, nmi, mem}
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {8'h01, 16'h6000, 1'b1, 1'b0, 20'h14000, 1'b0, 1'b0},
    {8'h02, 16'h9ABC, 1'b1, 1'b0, 20'h13ABC, 1'b0, 1'b0},
    {8'h3F, 16'hDFFF, 1'b1, 1'b0, 20'h8FFFF, 1'b0, 1'b0},
    {8'h80, 16'hA123, 1'b1, 1'b0, 20'h10123, 1'b0, 1'b1},
    {8'h40, 16'hC000, 1'b1, 1'b0, 20'h10000, 1'b1, 1'b0},
    {8'h15, 16'hB000, 1'b1, 1'b0, 20'h65000, 1'b0, 1'b0},
    {8'hC9, 16'h7FFF, 1'b1, 1'b0, 20'h1DFFF, 1'b1, 1'b1},
    {8'h36, 16'h8000, 1'b1, 1'b0, 20'h82000, 1'b0, 1'b0},
    {8'hFF, 16'h0000, 1'b1, 1'b0, 20'h00000, 1'b1, 1'b1},
    {8'hFF, 16'h57FF, 1'b1, 1'b0, 20'h057FF, 1'b1, 1'b1},
    {8'hFF, 16'h5800, 1'b0, 1'b0, 20'h00000, 1'b1, 1'b1},
    {8'hFF, 16'h5FFF, 1'b0, 1'b0, 20'h00000, 1'b1, 1'b1},
    {8'hFF, 16'hE000, 1'b0, 1'b1, 20'h00000, 1'b1, 1'b1},
    {8'hFF, 16'hFFFF, 1'b0, 1'b1, 20'h00000, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] data, input logic en);
    @(negedge clk);
    ioWrEn = en; ioAddr = port; ioData = data;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    cpuAddr = 16'h6000; #1;
    check("R8 romAddr after reset", 32'(romAddr), 32'h10000);
    check("R8 nmiEnable after reset", 32'(nmiEnable), 32'h0);
    check("R8 memFlag after reset", 32'(memFlag), 32'h0);
    rstN = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      ioWrite(8'h90, VEC[i][47:40], 1'b1);
      cpuAddr = VEC[i][39:24]; #1;
      check($sformatf("vec%0d R4/R5 romCs", i),  32'(romCs),    32'(VEC[i][23]));
      check($sformatf("vec%0d R5/R6 ramCs", i),  32'(ramCs),    32'(VEC[i][22]));
      check($sformatf("vec%0d R2/R3 romAddr", i), 32'(romAddr), 32'(VEC[i][21:2]));
      check($sformatf("vec%0d R7 nmiEnable", i), 32'(nmiEnable), 32'(VEC[i][1]));
      check($sformatf("vec%0d R7 memFlag", i),   32'(memFlag),  32'(VEC[i][0]));
    end

    // R3 four windows, same bank (bank 5 from data 0x0A)
    ioWrite(8'h90, 8'h0A, 1'b1);
    for (int w = 0; w < 4; w++) begin
      cpuAddr = 16'h6010 + 16'(w) * 16'h2000; #1;
      check($sformatf("R3 window %0d", w), 32'(romAddr), 32'h1A010);
    end

    // R1 write to a neighbouring port is ignored
    ioWrite(8'h91, 8'h01, 1'b1);
    cpuAddr = 16'h6000; #1;
    check("R1 other port ignored", 32'(romAddr), 32'h1A000);
    // R1 strobe low is ignored
    ioWrite(8'h90, 8'h01, 1'b0);
    #1;
    check("R1 strobe low ignored", 32'(romAddr), 32'h1A000);

    // R9 takes effect right after the storing edge
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = 8'h90; ioData = 8'h04;
    #1;
    check("R9 before edge", 32'(romAddr), 32'h1A000);
    @(posedge clk); #1;
    ioWrEn = 1'b0;
    check("R9 after edge", 32'(romAddr), 32'h20000);

    // R8 reset mid-run
    ioWrite(8'h90, 8'hFF, 1'b1);
    @(negedge clk); rstN = 1'b0; #1;
    check("R8 mid-run bank", 32'(romAddr), 32'h10000);
    check("R8 mid-run nmi", 32'(nmiEnable), 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule